// File: doc/BRIEF.md
# Four-Port Memory-Mapped GPIO Controller

This block is a general-purpose pin controller that hangs off a simple synchronous register bus with a byte-wide data path. It manages four ports of eight pins each. For every port, software programs a direction register and an output latch, reads back the pin levels, and receives change interrupts.

Each input pin passes through a two-stage synchronizer before anything uses it. A change event is a difference between the newest synchronized sample and the one taken a cycle earlier, so both rising and falling edges count. Events on input pins set sticky per-pin status bits, which software clears by writing ones. Each port raises its own interrupt request line. That line is the OR of the status bits the port's enable register lets through.

A bus access is a single-cycle strobe. A write takes effect at the clock edge that samples it. Read data appears on the edge after the read and stays there until the next read.

Top module: `gpio_ctrl`

## Requirements
- R1: While reset is high, and after it is released, every register is zero. `pin_oe`, `pin_out`, `irq` and `bus_rdata` are all zero, so every pin starts as an input with its interrupts off.
- R2: Port n's registers sit at these byte addresses:
  - output-latch/pin-level register at 0x1000 + 8n;
  - direction register at 0x1004 + 8n;
  - change-status register at 0x1040 + 16n;
  - interrupt-enable register at 0x1048 + 16n.

  A read of any other address returns 0, and a write to any other address changes nothing.
- R3: Direction bit 1 makes a pin an output and 0 makes it an input. `pin_oe` mirrors the direction bits. `pin_out` carries the latch bit for output pins and 0 for input pins.
- R4: A data-register write loads all eight latch bits. Bits of input pins do not reach `pin_out` until that pin is switched to output, and it then drives the stored value.
- R5: A data-register read returns the latch bit for output pins and the synchronized pin level for input pins.
- R6: For an input pin, a level change (rising or falling) that is present before clock edge k sets that pin's status bit at edge k+2. Pins in output mode never set status bits.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new event arrives at the same edge as the clear, the bit stays set.
- R8: `irq[n]` is high exactly when port n has a status bit set whose enable bit is also set. Other ports' lines are unaffected.
- R9: `bus_rdata` updates only at the edge that samples a read. Idle cycles and writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 32 | Pad input levels, port n in bits 8n+7..8n |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables |
| irq | output | 4 | Per-port interrupt requests |

## Verification
The bench times a pin change against the status edge exactly. A synchronizer that is one stage too short or too long moves the interrupt a cycle early or late, and the bench catches the shift. It reads back a port whose latch holds ones on input pins. A design that drives or returns the latch for input pins shows the wrong byte there. It also times a write-one-to-clear so that it lands at the same edge as a fresh event. A design where the clear wins loses that event. Finally, it reads an unmapped slot just past the last port and writes to it, which exposes a decoder that aliases addresses onto port 0.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_NUM_PORTS   = 4;
    localparam int GPIO_PINS        = 8;
    localparam int GPIO_ADDR_W      = 16;
    localparam int GPIO_PORT_BASE   = 'h1000;
    localparam int GPIO_PORT_STRIDE = 8;
    localparam int GPIO_EXT_BASE    = 'h1040;
    localparam int GPIO_EXT_STRIDE  = 16;

    localparam int OFS_LATCH = 0;
    localparam int OFS_DIR   = 4;
    localparam int OFS_STAT  = 0;
    localparam int OFS_IEN   = 8;

    // One select line per register inside a port.
    typedef struct packed {
        logic latch;
        logic dir;
        logic stat;
        logic ien;
    } port_sel_t;

    function automatic int reg_addr(int base, int idx, int stride, int ofs);
        return base + idx * stride + ofs;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice
    import gpio_pkg::*;
#(
    parameter int PINS = GPIO_PINS
) (
    input  logic            clk,
    input  logic            rst,
    input  port_sel_t       wr_sel,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] rd_level,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] stat_q,
    output logic [PINS-1:0] ien_q,
    output logic [PINS-1:0] pad_out,
    output logic            irq
);
    logic [PINS-1:0] latch_q;
    logic [PINS-1:0] synced;
    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] event_v;
    logic [PINS-1:0] clr_mask;
    logic [PINS-1:0] stat_d;

    gpio_in_sync #(.W(PINS)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (synced)
    );

    // Change events count only on pins configured as inputs.
    assign event_v  = (synced ^ prev_q) & ~dir_q;
    assign clr_mask = wr_sel.stat ? wdata : '0;
    // A new event outranks a same-cycle clear.
    assign stat_d   = (stat_q & ~clr_mask) | event_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            stat_q  <= '0;
            ien_q   <= '0;
            prev_q  <= '0;
        end else begin
            prev_q <= synced;
            stat_q <= stat_d;
            if (wr_sel.latch) latch_q <= wdata;
            if (wr_sel.dir)   dir_q   <= wdata;
            if (wr_sel.ien)   ien_q   <= wdata;
        end
    end

    assign rd_level = (latch_q & dir_q) | (synced & ~dir_q);
    assign pad_out  = latch_q & dir_q;
    assign irq      = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PORTS   = GPIO_NUM_PORTS,
    parameter int PINS        = GPIO_PINS,
    parameter int ADDR_W      = GPIO_ADDR_W,
    parameter int PORT_BASE   = GPIO_PORT_BASE,
    parameter int PORT_STRIDE = GPIO_PORT_STRIDE,
    parameter int EXT_BASE    = GPIO_EXT_BASE,
    parameter int EXT_STRIDE  = GPIO_EXT_STRIDE
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_en,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [PINS-1:0]           bus_wdata,
    output logic [PINS-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PINS-1:0] pin_in,
    output logic [NUM_PORTS*PINS-1:0] pin_out,
    output logic [NUM_PORTS*PINS-1:0] pin_oe,
    output logic [NUM_PORTS-1:0]      irq
);
    localparam int TOTAL = NUM_PORTS * PINS;

    port_sel_t       hit    [NUM_PORTS];
    port_sel_t       wr_sel [NUM_PORTS];
    logic [PINS-1:0] lvl_p  [NUM_PORTS];
    logic [PINS-1:0] dir_p  [NUM_PORTS];
    logic [PINS-1:0] stat_p [NUM_PORTS];
    logic [PINS-1:0] ien_p  [NUM_PORTS];
    logic [TOTAL-1:0] stat_flat;
    logic [PINS-1:0] rd_mux;
    logic [PINS-1:0] rdata_q;
    logic            wr_go;
    logic            rd_go;

    assign wr_go = bus_en & bus_we;
    assign rd_go = bus_en & ~bus_we;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] A_LATCH =
            ADDR_W'(reg_addr(PORT_BASE, p, PORT_STRIDE, OFS_LATCH));
        localparam logic [ADDR_W-1:0] A_DIR =
            ADDR_W'(reg_addr(PORT_BASE, p, PORT_STRIDE, OFS_DIR));
        localparam logic [ADDR_W-1:0] A_STAT =
            ADDR_W'(reg_addr(EXT_BASE, p, EXT_STRIDE, OFS_STAT));
        localparam logic [ADDR_W-1:0] A_IEN =
            ADDR_W'(reg_addr(EXT_BASE, p, EXT_STRIDE, OFS_IEN));

        assign hit[p].latch = (bus_addr == A_LATCH);
        assign hit[p].dir   = (bus_addr == A_DIR);
        assign hit[p].stat  = (bus_addr == A_STAT);
        assign hit[p].ien   = (bus_addr == A_IEN);
        assign wr_sel[p]    = hit[p] & {4{wr_go}};

        gpio_port_slice #(.PINS(PINS)) slice_i (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (wr_sel[p]),
            .wdata    (bus_wdata),
            .pad_in   (pin_in[p*PINS +: PINS]),
            .rd_level (lvl_p[p]),
            .dir_q    (dir_p[p]),
            .stat_q   (stat_p[p]),
            .ien_q    (ien_p[p]),
            .pad_out  (pin_out[p*PINS +: PINS]),
            .irq      (irq[p])
        );

        assign pin_oe[p*PINS +: PINS]    = dir_p[p];
        assign stat_flat[p*PINS +: PINS] = stat_p[p];
    end

    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (hit[p].latch) rd_mux = rd_mux | lvl_p[p];
            if (hit[p].dir)   rd_mux = rd_mux | dir_p[p];
            if (hit[p].stat)  rd_mux = rd_mux | stat_p[p];
            if (hit[p].ien)   rd_mux = rd_mux | ien_p[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_go) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
    parameter int NUM_PORTS = 4,
    parameter int PINS      = 8,
    parameter int ADDR_W    = 16,
    parameter int PORT_BASE = 'h1000
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_en,
    input logic                      bus_we,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [PINS-1:0]           bus_wdata,
    input logic [PINS-1:0]           bus_rdata,
    input logic [NUM_PORTS*PINS-1:0] pin_out,
    input logic [NUM_PORTS*PINS-1:0] pin_oe,
    input logic [NUM_PORTS-1:0]      irq,
    input logic [NUM_PORTS*PINS-1:0] stat_flat
);
    localparam logic [ADDR_W-1:0] DIR0 = ADDR_W'(PORT_BASE + 4);

    // R1: the cycle after reset is sampled, every output is quiet.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && irq == '0 && bus_rdata == '0));

    // R3: no pin drives a one while its output enable is low.
    assert_no_drive_input_R3: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);

    // R4: a direction write to port 0 shows on pin_oe one edge later.
    assert_dir_write_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == DIR0)
        |=> pin_oe[PINS-1:0] == $past(bus_wdata));

    // R6: a status bit can only newly set on a pin that was an input.
    assert_no_output_event_R6: assert property (@(posedge clk) disable iff (rst)
        ((stat_flat & ~$past(stat_flat)) & $past(pin_oe)) == '0);

    // R9: read data moves only after a read access.
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && !bus_we) |=> $stable(bus_rdata));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PINS      (PINS),
    .ADDR_W    (ADDR_W),
    .PORT_BASE (PORT_BASE)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .stat_flat (stat_flat)
);

// File: tb/gpio_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic        chk;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 16'h1004, 8'hF0, 1'b0, 8'h00, 8'd3},
        '{1'b1, 16'h1000, 8'hA5, 1'b0, 8'h00, 8'd4},
        '{1'b0, 16'h1000, 8'h00, 1'b1, 8'hA0, 8'd5},
        '{1'b0, 16'h1004, 8'h00, 1'b1, 8'hF0, 8'd2},
        '{1'b1, 16'h1058, 8'h3C, 1'b0, 8'h00, 8'd2},
        '{1'b0, 16'h1058, 8'h00, 1'b1, 8'h3C, 8'd2},
        '{1'b1, 16'h101C, 8'hFF, 1'b0, 8'h00, 8'd3},
        '{1'b1, 16'h1018, 8'h5A, 1'b0, 8'h00, 8'd4},
        '{1'b0, 16'h1018, 8'h00, 1'b1, 8'h5A, 8'd5},
        '{1'b0, 16'h1020, 8'h00, 1'b1, 8'h00, 8'd2},
        '{1'b1, 16'h1020, 8'hFF, 1'b0, 8'h00, 8'd2},
        '{1'b0, 16'h1000, 8'h00, 1'b1, 8'hA0, 8'd2},
        '{1'b1, 16'h1010, 8'hFF, 1'b0, 8'h00, 8'd4},
        '{1'b0, 16'h1010, 8'h00, 1'b1, 8'h00, 8'd4},
        '{1'b1, 16'h1014, 8'h0F, 1'b0, 8'h00, 8'd4},
        '{1'b0, 16'h1010, 8'h00, 1'b1, 8'h0F, 8'd4},
        '{1'b0, 16'h1060, 8'h00, 1'b1, 8'h00, 8'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_acc(input logic we, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 irq", {28'h0, irq}, 32'h0);
        check("R1 rdata", {24'h0, bus_rdata}, 32'h0);

        // Register walk (R2 R3 R4 R5)
        for (int i = 0; i < NVEC; i++) begin
            bus_acc(VEC[i].we, VEC[i].addr, VEC[i].wd);
            if (VEC[i].chk)
                check($sformatf("R%0d vec%0d", VEC[i].req, i), {24'h0, bus_rdata}, {24'h0, VEC[i].exp});
        end
        check("R3 pin_oe map", pin_oe, 32'hFF0F00F0);
        check("R3 R4 pin_out map", pin_out, 32'h5A0F00A0);

        // R6 R8: event on port1 bit0, not enabled
        pin_in[8] = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 masked irq", {28'h0, irq}, 32'h0);
        bus_acc(1'b0, 16'h1050, 8'h00);
        check("R6 stat bit0", {24'h0, bus_rdata}, 32'h01);

        // R6 exact timing on enabled bit2
        pin_in[10] = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 not yet at k+1", {28'h0, irq}, 32'h0);
        @(negedge clk);
        check("R6 R8 irq at k+2", {28'h0, irq}, 32'h2);
        bus_acc(1'b0, 16'h1008, 8'h00);
        check("R5 input level", {24'h0, bus_rdata}, 32'h05);

        // R7 write-one-to-clear
        bus_acc(1'b1, 16'h1050, 8'h01);
        bus_acc(1'b0, 16'h1050, 8'h00);
        check("R7 partial clear", {24'h0, bus_rdata}, 32'h04);
        check("R8 still pending", {28'h0, irq}, 32'h2);
        bus_acc(1'b1, 16'h1050, 8'h04);
        check("R7 R8 irq drop", {28'h0, irq}, 32'h0);
        bus_acc(1'b0, 16'h1050, 8'h00);
        check("R7 all clear", {24'h0, bus_rdata}, 32'h00);

        // R6 falling edge
        pin_in[10] = 1'b0;
        repeat (3) @(negedge clk);
        bus_acc(1'b0, 16'h1050, 8'h00);
        check("R6 falling", {24'h0, bus_rdata}, 32'h04);
        bus_acc(1'b1, 16'h1050, 8'h04);

        // R6 output pin ignores pad change, R5 reads latch
        pin_in[4] = 1'b1;
        repeat (4) @(negedge clk);
        bus_acc(1'b0, 16'h1040, 8'h00);
        check("R6 output no event", {24'h0, bus_rdata}, 32'h00);
        bus_acc(1'b0, 16'h1000, 8'h00);
        check("R5 output reads latch", {24'h0, bus_rdata}, 32'hA0);

        // R7 clear collides with new event at edge k+2
        pin_in[10] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 16'h1050; bus_wdata = 8'h04;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        bus_acc(1'b0, 16'h1050, 8'h00);
        check("R7 event beats clear", {24'h0, bus_rdata}, 32'h04);
        check("R8 port isolation", {28'h0, irq}, 32'h2);

        // R9 read data holds over idle and writes
        bus_acc(1'b0, 16'h101C, 8'h00);
        check("R9 read", {24'h0, bus_rdata}, 32'hFF);
        repeat (2) @(negedge clk);
        bus_acc(1'b1, 16'h1018, 8'h33);
        check("R9 hold", {24'h0, bus_rdata}, 32'hFF);
        check("R4 new latch", {24'h0, pin_out[31:24]}, 32'h33);

        // R1 mid-run reset
        pin_in = '0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset oe", pin_oe, 32'h0);
        check("R1 reset out", pin_out, 32'h0);
        check("R1 reset irq", {28'h0, irq}, 32'h0);
        check("R1 reset rdata", {24'h0, bus_rdata}, 32'h0);
        bus_acc(1'b0, 16'h1058, 8'h00);
        check("R1 ien zero", {24'h0, bus_rdata}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule